// File: doc/BRIEF.md
# Low-Power DDR Power-Up Initialization Sequencer

This block sits on the controller side of a mobile low-power DDR SDRAM interface. It takes the memory from power-on to an idle state in which the first row activation is legal. After reset is released, it drives NOP for a configured number of clock cycles, which covers the 200 microsecond stabilization interval. It then issues one precharge to every bank, two auto-refresh commands, a load of the mode register and a load of the extended mode register. Between each command and the next it waits a configured gap of tRP, tRFC or tMRD clock cycles.

The mode register opcode is built from three configuration inputs: burst length, burst type and read (CAS) latency. The extended mode register opcode is passed through from a configuration input. When the last gap has elapsed, the block raises a sticky completion flag and permits the data-path drivers to be enabled. Every gap parameter must be at least 2 cycles, and the address width must be at least 11 bits.

Top module: `lpddr_init_seq`

## Requirements
- R1: While reset is asserted and for the first T_PWRUP clock edges after its release, the command on {cs_n, ras_n, cas_n, we_n} is NOP = 4'b0111. The first other command appears right after rising edge number T_PWRUP.
- R2: Only five commands are issued, in this order: precharge (4'b0010), auto refresh (4'b0001), auto refresh, mode load (4'b0000 with ba = 2'b00), extended mode load (4'b0000 with ba = 2'b10, meaning bank bit 1 high and bank bit 0 low).
- R3: Command spacing, counted in clock edges, is exactly T_RP from the precharge to the first refresh, T_RFC between the two refreshes, T_RFC from the second refresh to the mode load, and T_MRD from the mode load to the extended load. init_done rises T_MRD edges after the extended load.
- R4: The precharge drives address bit 10 high and every other address bit low.
- R5: The mode load drives burst length on addr[2:0], burst type on addr[3] (0 sequential, 1 interleave) and latency on addr[6:4], with all higher bits 0.
- R6: The extended mode load drives the full cfg_ext_mode value on the address bus.
- R7: Every command lasts a single cycle and is followed by NOP. cs_n is never high.
- R8: cke is low while reset is asserted and high from the first edge after release onward.
- R9: init_done and dq_oe are low until the sequence completes. After that they stay high and only NOP is issued, until the next reset.
- R10: A reset asserted in the middle of the sequence, or after it, clears init_done and restarts the full power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_burst_len | input | 3 | Burst length code for the mode register |
| cfg_burst_type | input | 1 | Burst type: 0 sequential, 1 interleave |
| cfg_cas_lat | input | 3 | Read latency code for the mode register |
| cfg_ext_mode | input | ADDR_W | Extended mode register opcode |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address / opcode bus |
| dq_oe | output | 1 | Permission to enable the data and strobe drivers |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
A wrong state or a wrong counter value in this block changes which command appears on the bus, or the cycle in which it appears. Either fault shows within one gap interval. The bench therefore logs every non-NOP command against its expected edge number, so a missing or extra command is caught, and so is a gap that is short or long by a single cycle. The opcodes are checked under several configuration patterns, so a swapped or shifted opcode field shows on the address bus in the load cycle itself. A stuck or late completion flag shows within T_MRD cycles of the extended load.

// File: rtl/lpddr_init_pkg.sv
package lpddr_init_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP    = 4'd0,
    ST_ISS_PRE  = 4'd1,
    ST_WAIT_RP  = 4'd2,
    ST_ISS_REF1 = 4'd3,
    ST_WAIT_RF1 = 4'd4,
    ST_ISS_REF2 = 4'd5,
    ST_WAIT_RF2 = 4'd6,
    ST_ISS_MODE = 4'd7,
    ST_WAIT_MD1 = 4'd8,
    ST_ISS_EXT  = 4'd9,
    ST_WAIT_MD2 = 4'd10,
    ST_READY    = 4'd11
  } init_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_PRE  = 4'b0010;
  localparam logic [3:0] CMD_REF  = 4'b0001;
  localparam logic [3:0] CMD_LOAD = 4'b0000;

  localparam logic [1:0] BANK_MODE = 2'b00;
  localparam logic [1:0] BANK_EXT  = 2'b10;

endpackage

// File: rtl/lpddr_init_timer.sv
module lpddr_init_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Reload on a command issue, otherwise count down and stop at zero.
  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // A wait state leaves on the cycle that the count reaches one, so the next
  // command lands exactly the loaded value + 1 edges after its predecessor.
  assign expired = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/lpddr_init_fsm.sv
module lpddr_init_fsm
  import lpddr_init_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int T_RP  = 3,
  parameter int T_RFC = 10,
  parameter int T_MRD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expired,
  output init_state_t      state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] GAP_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] GAP_RFC = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] GAP_MRD = CNT_W'(T_MRD - 1);

  init_state_t state_q;
  init_state_t state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_PWRUP:    if (expired) state_d = ST_ISS_PRE;
      ST_ISS_PRE:  begin tmr_load = 1'b1; tmr_val = GAP_RP;  state_d = ST_WAIT_RP;  end
      ST_WAIT_RP:  if (expired) state_d = ST_ISS_REF1;
      ST_ISS_REF1: begin tmr_load = 1'b1; tmr_val = GAP_RFC; state_d = ST_WAIT_RF1; end
      ST_WAIT_RF1: if (expired) state_d = ST_ISS_REF2;
      ST_ISS_REF2: begin tmr_load = 1'b1; tmr_val = GAP_RFC; state_d = ST_WAIT_RF2; end
      ST_WAIT_RF2: if (expired) state_d = ST_ISS_MODE;
      ST_ISS_MODE: begin tmr_load = 1'b1; tmr_val = GAP_MRD; state_d = ST_WAIT_MD1; end
      ST_WAIT_MD1: if (expired) state_d = ST_ISS_EXT;
      ST_ISS_EXT:  begin tmr_load = 1'b1; tmr_val = GAP_MRD; state_d = ST_WAIT_MD2; end
      ST_WAIT_MD2: if (expired) state_d = ST_READY;
      ST_READY:    state_d = ST_READY;
      default:     state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/lpddr_init_cmd.sv
module lpddr_init_cmd
  import lpddr_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  init_state_t       state,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [ADDR_W-1:0] cfg_ext_mode,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  localparam int MODE_W = 7;
  localparam int AP_BIT = 10;

  logic [ADDR_W-1:0] mode_op;
  logic [ADDR_W-1:0] pre_all;
  logic              cke_q;

  always_comb begin
    mode_op = '0;
    mode_op[MODE_W-1:0] = {cfg_cas_lat, cfg_burst_type, cfg_burst_len};
    pre_all = '0;
    pre_all[AP_BIT] = 1'b1;
  end

  always_comb begin
    cmd  = CMD_NOP;
    ba   = 2'b00;
    addr = '0;
    unique case (state)
      ST_ISS_PRE:  begin cmd = CMD_PRE; addr = pre_all; end
      ST_ISS_REF1,
      ST_ISS_REF2: cmd = CMD_REF;
      ST_ISS_MODE: begin cmd = CMD_LOAD; ba = BANK_MODE; addr = mode_op; end
      ST_ISS_EXT:  begin cmd = CMD_LOAD; ba = BANK_EXT;  addr = cfg_ext_mode; end
      default:     cmd = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q <= 1'b0;
    end else begin
      cke_q <= 1'b1;
    end
  end

  assign cke   = cke_q;
  assign ready = (state == ST_READY);

endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
  import lpddr_init_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int T_PWRUP = 25000,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 10,
  parameter int T_MRD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [ADDR_W-1:0] cfg_ext_mode,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dq_oe,
  output logic              init_done
);

  localparam int GAP_MAX = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                          : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
  localparam int CNT_MAX = (T_PWRUP > GAP_MAX) ? T_PWRUP : GAP_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  init_state_t      state;
  logic             expired;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [3:0]       cmd;
  logic             ready;

  lpddr_init_timer #(.CNT_W(CNT_W), .RST_VAL(T_PWRUP)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  lpddr_init_fsm #(.CNT_W(CNT_W), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .expired  (expired),
    .state    (state),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  lpddr_init_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk            (clk),
    .rst_n          (rst_n),
    .state          (state),
    .cfg_burst_len  (cfg_burst_len),
    .cfg_burst_type (cfg_burst_type),
    .cfg_cas_lat    (cfg_cas_lat),
    .cfg_ext_mode   (cfg_ext_mode),
    .cke            (cke),
    .cmd            (cmd),
    .ba             (ba),
    .addr           (addr),
    .ready          (ready)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign init_done = ready;
  assign dq_oe     = ready;

endmodule

// File: rtl/lpddr_init_seq_chk.sv
module lpddr_init_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  logic [3:0] cmd_w;
  assign cmd_w = {cs_n, ras_n, cas_n, we_n};

  p_single_cycle_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w != 4'b0111) |=> (cmd_w == 4'b0111));

  p_cs_low_r7: assert property (@(posedge clk) disable iff (!rst_n) !cs_n);

  p_cke_stays_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd_w == 4'b0111));

  p_precharge_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == 4'b0010) |-> addr[10]);

  p_load_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == 4'b0000) |-> (ba == 2'b00 || ba == 2'b10));

  p_mode_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == 4'b0000 && ba == 2'b00) |-> (addr[ADDR_W-1:7] == '0));

  p_done_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> ($past(cmd_w) == 4'b0111));

endmodule

bind lpddr_init_seq lpddr_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .addr      (addr),
  .init_done (init_done)
);

// File: tb/lpddr_init_seq_bench.sv
module lpddr_init_seq_bench;

  localparam int ADDR_W  = 13;
  localparam int T_PWRUP = 40;
  localparam int T_RP    = 3;
  localparam int T_RFC   = 7;
  localparam int T_MRD   = 2;

  localparam int AT_PRE  = T_PWRUP;
  localparam int AT_REF1 = AT_PRE + T_RP;
  localparam int AT_REF2 = AT_REF1 + T_RFC;
  localparam int AT_MODE = AT_REF2 + T_RFC;
  localparam int AT_EXT  = AT_MODE + T_MRD;
  localparam int AT_DONE = AT_EXT + T_MRD;

  logic              clk;
  logic              rst_n;
  logic [2:0]        cfg_burst_len;
  logic              cfg_burst_type;
  logic [2:0]        cfg_cas_lat;
  logic [ADDR_W-1:0] cfg_ext_mode;
  logic              cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]        ba;
  logic [ADDR_W-1:0] addr;
  logic              dq_oe, init_done;

  int checks;
  int errors;
  bit finished;

  lpddr_init_seq #(
    .ADDR_W(ADDR_W), .T_PWRUP(T_PWRUP), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_lpddr_init_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_burst_len(cfg_burst_len), .cfg_burst_type(cfg_burst_type),
    .cfg_cas_lat(cfg_cas_lat), .cfg_ext_mode(cfg_ext_mode),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .dq_oe(dq_oe), .init_done(init_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] cmd_now();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  // R1, R8, R9: outputs while reset is held.
  task automatic check_in_reset(input string req);
    chk(cmd_now() == 4'b0111, req, "cmd in reset", 32'(cmd_now()), 32'h7);
    chk(cke == 1'b0, "R8", "cke in reset", 32'(cke), 32'h0);
    chk(init_done == 1'b0, req, "done in reset", 32'(init_done), 32'h0);
    chk(dq_oe == 1'b0, "R9", "dq_oe in reset", 32'(dq_oe), 32'h0);
  endtask

  // Full sequence: reset, release, walk every edge and compare.
  task automatic run_sequence(input logic [2:0] bl, input logic bt,
                              input logic [2:0] cl, input logic [ADDR_W-1:0] ext,
                              input int stop_at, output int first_cmd_at);
    logic [3:0]        exp_cmd;
    logic [1:0]        exp_ba;
    logic [ADDR_W-1:0] exp_addr;
    logic [ADDR_W-1:0] mode_exp;
    int                bad_cmd;
    int                bad_cke;
    first_cmd_at = -1;
    bad_cmd = 0;
    bad_cke = 0;
    cfg_burst_len  = bl;
    cfg_burst_type = bt;
    cfg_cas_lat    = cl;
    cfg_ext_mode   = ext;
    mode_exp = '0;
    mode_exp[6:0] = {cl, bt, bl};
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_in_reset("R1");
    rst_n = 1'b1;
    for (int n = 1; n <= stop_at; n++) begin
      @(negedge clk);
      exp_cmd = 4'b0111; exp_ba = 2'b00; exp_addr = '0;
      if (n == AT_PRE) begin exp_cmd = 4'b0010; exp_addr[10] = 1'b1; end
      if (n == AT_REF1 || n == AT_REF2) exp_cmd = 4'b0001;
      if (n == AT_MODE) begin exp_cmd = 4'b0000; exp_addr = mode_exp; end
      if (n == AT_EXT)  begin exp_cmd = 4'b0000; exp_ba = 2'b10; exp_addr = ext; end
      if (cmd_now() != 4'b0111 && first_cmd_at < 0) first_cmd_at = n;
      if (cmd_now() != exp_cmd) begin
        bad_cmd++;
        chk(1'b0, (n < AT_PRE) ? "R1" : "R3", $sformatf("cmd at edge %0d", n),
            32'(cmd_now()), 32'(exp_cmd));
      end
      if (!cke) bad_cke++;
      if (n == AT_PRE)
        chk(addr == exp_addr, "R4", "precharge address", 32'(addr), 32'(exp_addr));
      if (n == AT_MODE) begin
        chk(ba == 2'b00, "R2", "mode load bank", 32'(ba), 32'h0);
        chk(addr == exp_addr, "R5", "mode opcode", 32'(addr), 32'(exp_addr));
      end
      if (n == AT_EXT) begin
        chk(ba == 2'b10, "R2", "extended load bank", 32'(ba), 32'h2);
        chk(addr == exp_addr, "R6", "extended opcode", 32'(addr), 32'(exp_addr));
      end
      if (n == AT_DONE - 1)
        chk(init_done == 1'b0, "R3", "done one edge early", 32'(init_done), 32'h0);
      if (n == AT_DONE) begin
        chk(init_done == 1'b1, "R3", "done on time", 32'(init_done), 32'h1);
        chk(dq_oe == 1'b1, "R9", "dq_oe on done", 32'(dq_oe), 32'h1);
      end
      if (n < AT_DONE && (init_done || dq_oe)) begin
        chk(1'b0, "R9", $sformatf("early done/oe at edge %0d", n),
            32'({init_done, dq_oe}), 32'h0);
      end
    end
    chk(bad_cmd == 0, "R7", "commands single-cycle and in order", 32'(bad_cmd), 32'h0);
    chk(bad_cke == 0, "R8", "cke high after release", 32'(bad_cke), 32'h0);
  endtask

  task automatic test_basic();
    int first;
    run_sequence(3'b010, 1'b0, 3'b011, 13'h0020, AT_DONE + 6, first);
    chk(first == AT_PRE, "R1", "first command edge", 32'(first), 32'(AT_PRE));
    chk(init_done == 1'b1, "R9", "done sticky", 32'(init_done), 32'h1);
  endtask

  task automatic test_interleave_pattern();
    int first;
    run_sequence(3'b011, 1'b1, 3'b010, 13'h1ABC, AT_DONE + 3, first);
    chk(first == AT_PRE, "R2", "sequence start", 32'(first), 32'(AT_PRE));
  endtask

  task automatic test_all_ones();
    int first;
    run_sequence(3'b111, 1'b1, 3'b111, {ADDR_W{1'b1}}, AT_DONE + 2, first);
    chk(first == AT_PRE, "R6", "sequence start", 32'(first), 32'(AT_PRE));
  endtask

  task automatic test_mid_reset();
    int first;
    run_sequence(3'b001, 1'b0, 3'b010, 13'h0005, AT_REF1 + 2, first);
    rst_n = 1'b0;
    @(negedge clk);
    check_in_reset("R10");
    run_sequence(3'b001, 1'b0, 3'b010, 13'h0005, AT_DONE + 1, first);
    chk(first == AT_PRE, "R10", "restart after mid reset", 32'(first), 32'(AT_PRE));
    rst_n = 1'b0;
    @(negedge clk);
    chk(init_done == 1'b0, "R10", "done cleared by reset", 32'(init_done), 32'h0);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    cfg_burst_len = '0;
    cfg_burst_type = 1'b0;
    cfg_cas_lat = '0;
    cfg_ext_mode = '0;
    repeat (3) @(negedge clk);
    check_in_reset("R1");
    test_basic();
    test_interleave_pattern();
    test_all_ones();
    test_mid_reset();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule